// File: doc/BRIEF.md
# Two-Wire Register Slave with Block and Indexed Access

This block is a serial slave on a two-wire bus (clock line plus open-drain data line) that lets an external controller read and write a small bank of 8-bit configuration registers. Every register is also presented in parallel on an output bus, so the rest of the chip sees the configuration at once. The clock and data lines are brought into the system clock domain through two-stage synchronisers and sampled there. Start, repeated-start and stop conditions are detected from the relative timing of the two lines.

After its own 7-bit address and a write bit, the slave takes an 8-bit command code. Bit 7 of that code selects the access mode. When it is set, bits 6:0 are a register offset and the following data bytes are written from that offset upward. A later read then returns bytes from the same offset. When bit 7 is clear, the transfer is a block access that always begins at register 0. A block write carries a byte count that the slave acknowledges and ignores. A block read continues with a repeated start and the address with the read bit. The slave then sends the bank depth as a byte count, followed by the registers in ascending order.

The slave only ever pulls the data line low, and it changes its drive only while the clock line is low. Clock stretching, packet error checks and arbitration are not part of it.

Top module: `smbreg_slave`

## Requirements
- R1: After reset every register in the bank reads 0 on the parallel output and the data line is released (sda_drive_low = 0).
- R2: A byte matching {DEV_ADDR, rw} after a start is acknowledged (data line pulled low during the ninth clock). A different address is not acknowledged, and every later byte up to the next start is neither acknowledged nor allowed to change a register.
- R3: A command code with bit 7 = 1 makes the following written bytes land at the offset in bits 6:0, then at offset+1 (word write), and so on upward. The new value is committed in the low phase of the clock after the eighth bit, before the acknowledge.
- R4: A command code with bit 7 = 0 starts a block write. The next byte is a byte count, which is acknowledged and ignored, and the data bytes after it go to registers 0, 1, 2 … in that order.
- R5: Written bytes whose target index is DEPTH or above are acknowledged and discarded, and no register changes.
- R6: A block read (command 8'h00, repeated start, address with the read bit) returns DEPTH as the first byte, then register 0, 1, 2 … in ascending order.
- R7: An indexed read (command with bit 7 = 1, repeated start, address with the read bit) returns the register at the offset, then the following registers in order. An index of DEPTH or above reads as 8'hFF.
- R8: When the master does not acknowledge a byte it read, the slave releases the data line for the rest of the transfer, so further clocks read 8'hFF.
- R9: A stop that arrives before the eighth bit of a written byte leaves every register unchanged.
- R10: The only data-line output is a pull-low enable, and it changes only while the clock line is low.
- R11: A start or stop condition releases the data line. After a stop the slave is idle and drives nothing until it is addressed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_drive_low | output | 1 | 1 = pull the data line low, 0 = release it |
| regs_o | output | DEPTH*8 | All registers side by side, register i at bits [8i+7:8i] |

## Verification
A wrong bit counter or a state left over from a stop shows up within one byte time. It appears as a missing or misplaced acknowledge on the data line, or as a write that lands on the parallel register outputs at the wrong index. A corrupted pointer or mode flag shows at the ports in the next read, as a shifted or wrong byte sequence. The block-read byte count and the 8'hFF fill beyond the bank expose a bad end-of-bank decision in the same transfer. A pull-low enable that moves while the clock line is high would turn into a false start or stop for other devices on the bus. It is watched on every cycle, so it is caught on the first bit where it happens.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

    localparam int OFS_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_WDATA,
        ST_TX,
        ST_SKIP
    } eng_state_t;

    typedef struct packed {
        logic             indexed;
        logic [OFS_W-1:0] ofs;
    } cmd_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic takes_bits(eng_state_t s);
        return (s == ST_ADDR) || (s == ST_CMD) || (s == ST_COUNT) ||
               (s == ST_WDATA) || (s == ST_TX);
    endfunction

    function automatic logic [OFS_W-1:0] step_ptr(logic [OFS_W-1:0] p);
        return (p == {OFS_W{1'b1}}) ? p : p + 1'b1;
    endfunction

endpackage

// File: rtl/smbreg_line_sync.sv
module smbreg_line_sync
    import smbreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_s,
    output logic    sda_s,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
    end

endmodule

// File: rtl/smbreg_bank.sv
module smbreg_bank #(
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [AW-1:0]      rd_idx,
    output logic [7:0]         rd_data,
    output logic [DEPTH*8-1:0] regs_o
);

    logic [DEPTH-1:0][7:0] mem;
    logic [DEPTH-1:0]      we_vec;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_we
            assign we_vec[g] = wr_en && (wr_idx == AW'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (we_vec[i]) mem[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == AW'(i)) rd_data = mem[i];
        end
    end

    assign regs_o = mem;

endmodule

// File: rtl/smbreg_engine.sv
module smbreg_engine
    import smbreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h52,
    parameter int         DEPTH    = 8,
    parameter int         AW       = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic          sda_s,
    output logic          drv_low,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] rd_idx,
    input  logic [7:0]    rd_data
);

    localparam logic [7:0] CNT_BYTE = 8'(DEPTH);

    eng_state_t       state;
    logic [3:0]       bitcnt;
    logic             slv_ack;
    logic             mst_ack;
    logic             mst_nack;
    logic [7:0]       shreg;
    logic [7:0]       txreg;
    logic [OFS_W-1:0] ptr;
    logic             blk_mode;

    logic             ptr_ok;
    logic [7:0]       rd_byte;
    logic             byte_done;
    cmd_t             cmd_in;

    assign ptr_ok    = {1'b0, ptr} < CNT_BYTE;
    assign rd_byte   = ptr_ok ? rd_data : 8'hFF;
    assign rd_idx    = ptr[AW-1:0];
    assign cmd_in    = cmd_t'(shreg);
    assign byte_done = ev.fall && !slv_ack && !mst_ack && (bitcnt == 4'd8);

    assign wr_en   = byte_done && (state == ST_WDATA) && ptr_ok;
    assign wr_idx  = ptr[AW-1:0];
    assign wr_data = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            slv_ack  <= 1'b0;
            mst_ack  <= 1'b0;
            mst_nack <= 1'b0;
            shreg    <= '0;
            txreg    <= '0;
            ptr      <= '0;
            blk_mode <= 1'b0;
            drv_low  <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_ADDR;
            bitcnt  <= '0;
            slv_ack <= 1'b0;
            mst_ack <= 1'b0;
            drv_low <= 1'b0;
        end else if (ev.stop) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            slv_ack <= 1'b0;
            mst_ack <= 1'b0;
            drv_low <= 1'b0;
        end else begin
            if (ev.rise) begin
                if (mst_ack) begin
                    mst_nack <= sda_s;
                end else if (!slv_ack && bitcnt < 4'd8 && takes_bits(state)) begin
                    shreg  <= {shreg[6:0], sda_s};
                    bitcnt <= bitcnt + 4'd1;
                end
            end
            if (ev.fall) begin
                if (slv_ack) begin
                    slv_ack <= 1'b0;
                    bitcnt  <= '0;
                    drv_low <= (state == ST_TX) ? ~txreg[7] : 1'b0;
                end else if (mst_ack) begin
                    mst_ack <= 1'b0;
                    bitcnt  <= '0;
                    if (mst_nack) begin
                        state   <= ST_SKIP;
                        drv_low <= 1'b0;
                    end else begin
                        txreg   <= rd_byte;
                        drv_low <= ~rd_byte[7];
                        ptr     <= step_ptr(ptr);
                    end
                end else if (bitcnt == 4'd8) begin
                    case (state)
                        ST_ADDR: begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                slv_ack <= 1'b1;
                                drv_low <= 1'b1;
                                if (shreg[0]) begin
                                    state <= ST_TX;
                                    if (blk_mode) begin
                                        txreg <= CNT_BYTE;
                                    end else begin
                                        txreg <= rd_byte;
                                        ptr   <= step_ptr(ptr);
                                    end
                                end else begin
                                    state <= ST_CMD;
                                end
                            end else begin
                                state   <= ST_SKIP;
                                drv_low <= 1'b0;
                            end
                        end
                        ST_CMD: begin
                            slv_ack  <= 1'b1;
                            drv_low  <= 1'b1;
                            blk_mode <= ~cmd_in.indexed;
                            ptr      <= cmd_in.indexed ? cmd_in.ofs : '0;
                            state    <= cmd_in.indexed ? ST_WDATA : ST_COUNT;
                        end
                        ST_COUNT: begin
                            slv_ack <= 1'b1;
                            drv_low <= 1'b1;
                            state   <= ST_WDATA;
                        end
                        ST_WDATA: begin
                            slv_ack <= 1'b1;
                            drv_low <= 1'b1;
                            ptr     <= step_ptr(ptr);
                        end
                        ST_TX: begin
                            drv_low <= 1'b0;
                            mst_ack <= 1'b1;
                        end
                        default: begin
                        end
                    endcase
                end else if (state == ST_TX && bitcnt != 4'd0) begin
                    txreg   <= {txreg[6:0], 1'b0};
                    drv_low <= ~txreg[6];
                end
            end
        end
    end

endmodule

// File: rtl/smbreg_slave.sv
module smbreg_slave
    import smbreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h52,
    parameter int         DEPTH    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_drive_low,
    output logic [DEPTH*8-1:0] regs_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    bus_ev_t       bus_ev;
    logic          scl_s;
    logic          sda_s;
    logic          wr_en;
    logic [AW-1:0] wr_idx;
    logic [7:0]    wr_data;
    logic [AW-1:0] rd_idx;
    logic [7:0]    rd_data;

    smbreg_line_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .ev    (bus_ev)
    );

    smbreg_engine #(.DEV_ADDR(DEV_ADDR), .DEPTH(DEPTH), .AW(AW)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .ev      (bus_ev),
        .sda_s   (sda_s),
        .drv_low (sda_drive_low),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    smbreg_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

endmodule

// File: rtl/smbreg_slave_chk.sv
module smbreg_slave_chk
    import smbreg_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               scl_s,
    input bus_ev_t            ev,
    input logic               drv,
    input logic               wr_en,
    input logic [DEPTH*8-1:0] regs
);

    // R10
    drv_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(drv) && !$past(ev.start || ev.stop)) |-> !scl_s);

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !drv);

    // R11
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !drv);

    // R9
    reg_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(regs) |-> $past(wr_en));

    // R3
    write_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !scl_s);

endmodule

bind smbreg_slave smbreg_slave_chk #(.DEPTH(DEPTH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .scl_s (scl_s),
    .ev    (bus_ev),
    .drv   (sda_drive_low),
    .wr_en (wr_en),
    .regs  (regs_o)
);

// File: tb/sim_smbreg_slave.sv
module sim_smbreg_slave;

    localparam logic [6:0] DEV   = 7'h52;
    localparam int         DEPTH = 8;
    localparam int         H     = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               scl = 1'b1;
    logic               m_low = 1'b0;
    logic               sda_line;
    logic               sda_drive_low;
    logic [DEPTH*8-1:0] regs_o;

    int   checks = 0;
    int   errors = 0;
    int   viol = 0;
    bit   done = 1'b0;
    logic prev_drv = 1'b0;
    logic [7:0] mdl [DEPTH];

    always #2 clk = ~clk;

    assign sda_line = !(m_low || sda_drive_low);

    smbreg_slave #(.DEV_ADDR(DEV), .DEPTH(DEPTH)) u0 (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl),
        .sda_i         (sda_line),
        .sda_drive_low (sda_drive_low),
        .regs_o        (regs_o)
    );

    // R10: pull-low enable may move only while the clock line is low
    always @(posedge clk) begin
        if (!rst && sda_drive_low != prev_drv && scl) viol++;
        prev_drv <= sda_drive_low;
    end

    task automatic w(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(int idx);
        return (idx < DEPTH) ? mdl[idx] : 8'hFF;
    endfunction

    function automatic void mdl_wr(int idx, logic [7:0] d);
        if (idx < DEPTH) mdl[idx] = d;
    endfunction

    task automatic check_regs(string req);
        for (int i = 0; i < DEPTH; i++)
            chk(regs_o[i*8 +: 8] == mdl[i], req, {24'h0, regs_o[i*8 +: 8]}, {24'h0, mdl[i]});
    endtask

    task automatic b_start();
        if (scl) begin
            m_low = 1'b1; w(H); scl = 1'b0; w(H/2);
        end else begin
            m_low = 1'b0; w(H/2); scl = 1'b1; w(H); m_low = 1'b1; w(H); scl = 1'b0; w(H/2);
        end
    endtask

    task automatic b_stop();
        m_low = 1'b1; w(H); scl = 1'b1; w(H); m_low = 1'b0; w(2*H);
    endtask

    task automatic b_wbits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            w(H/2); m_low = !b[i]; w(H/2); scl = 1'b1; w(H); scl = 1'b0;
        end
    endtask

    task automatic b_wbyte(logic [7:0] b, output logic ack);
        b_wbits(b, 8);
        w(H/2); m_low = 1'b0; w(H/2); scl = 1'b1; w(H/2); ack = !sda_line; w(H/2); scl = 1'b0;
    endtask

    task automatic b_rbyte(logic give_ack, output logic [7:0] d);
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            w(H/2); m_low = 1'b0; w(H/2); scl = 1'b1; w(H/2); d = {d[6:0], sda_line}; w(H/2); scl = 1'b0;
        end
        w(H/2); m_low = give_ack; w(H/2); scl = 1'b1; w(H); scl = 1'b0;
    endtask

    task automatic open_cmd(logic [7:0] cmd, string req);
        logic a;
        b_start();
        b_wbyte({DEV, 1'b0}, a);
        chk(a == 1'b1, "R2", {31'h0, a}, 32'h1);
        b_wbyte(cmd, a);
        chk(a == 1'b1, req, {31'h0, a}, 32'h1);
    endtask

    task automatic idx_write(int ofs, int n);
        logic a;
        logic [7:0] d;
        open_cmd(8'h80 | 8'(ofs), "R3");
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            b_wbyte(d, a);
            chk(a == 1'b1, (ofs + k >= DEPTH) ? "R5" : "R3", {31'h0, a}, 32'h1);
            mdl_wr(ofs + k, d);
        end
        b_stop();
        check_regs((ofs + n > DEPTH) ? "R5" : "R3");
    endtask

    task automatic blk_write(int n);
        logic a;
        logic [7:0] d;
        open_cmd(8'h00, "R4");
        b_wbyte(8'(n), a);
        chk(a == 1'b1, "R4", {31'h0, a}, 32'h1);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            b_wbyte(d, a);
            chk(a == 1'b1, (k >= DEPTH) ? "R5" : "R4", {31'h0, a}, 32'h1);
            mdl_wr(k, d);
        end
        b_stop();
        check_regs((n > DEPTH) ? "R5" : "R4");
    endtask

    // n bytes read in total; the last is not acknowledged; extra adds a byte after it
    task automatic do_read(logic [7:0] cmd, int n, bit extra);
        logic a;
        logic [7:0] d;
        logic [7:0] e;
        bit blk;
        int ofs;
        blk = !cmd[7];
        ofs = int'(cmd[6:0]);
        open_cmd(cmd, blk ? "R6" : "R7");
        b_start();
        b_wbyte({DEV, 1'b1}, a);
        chk(a == 1'b1, "R2", {31'h0, a}, 32'h1);
        for (int k = 0; k < n; k++) begin
            b_rbyte(k != n - 1, d);
            if (blk) e = (k == 0) ? 8'(DEPTH) : exp_rd(k - 1);
            else     e = exp_rd(ofs + k);
            chk(d == e, blk ? "R6" : "R7", {24'h0, d}, {24'h0, e});
        end
        if (extra) begin
            b_rbyte(1'b0, d);
            chk(d == 8'hFF, "R8", {24'h0, d}, 32'hFF);
        end
        b_stop();
        chk(sda_drive_low == 1'b0, "R11", {31'h0, sda_drive_low}, 32'h0);
    endtask

    task automatic bad_addr();
        logic a;
        b_start();
        b_wbyte({DEV ^ 7'h01, 1'b0}, a);
        chk(a == 1'b0, "R2", {31'h0, a}, 32'h0);
        b_wbyte(8'h81, a);
        chk(a == 1'b0, "R2", {31'h0, a}, 32'h0);
        b_wbyte(8'h5A, a);
        chk(a == 1'b0, "R2", {31'h0, a}, 32'h0);
        b_stop();
        check_regs("R2");
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic a;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
        w(6);
        rst = 1'b0;
        w(6);

        // R1 reset state
        check_regs("R1");
        chk(sda_drive_low == 1'b0, "R1", {31'h0, sda_drive_low}, 32'h0);

        // R3 indexed byte and word writes
        idx_write(3, 1);
        idx_write(5, 2);
        // R5 word write straddling the end of the bank
        idx_write(DEPTH - 1, 2);
        // R4 / R5 block writes
        blk_write(4);
        blk_write(DEPTH + 2);
        blk_write(0);

        // R6 full block read past the end, R7 indexed reads
        do_read(8'h00, DEPTH + 3, 1'b0);
        do_read(8'h80 | 8'(DEPTH - 3), 3, 1'b0);
        do_read(8'h80 | 8'(DEPTH - 1), 2, 1'b0);
        // R8 clocks after a master not-acknowledge read released line
        do_read(8'h82, 2, 1'b1);

        // R2 foreign address
        bad_addr();

        // R9 stop after four bits of a data byte
        open_cmd(8'h82, "R9");
        b_wbits(8'h3C, 4);
        b_stop();
        check_regs("R9");
        // R9 the slave answers normally afterwards
        idx_write(2, 1);

        // constrained random mix
        for (int t = 0; t < 24; t++) begin
            case ($urandom_range(0, 4))
                0: idx_write($urandom_range(0, DEPTH + 1), $urandom_range(1, 2));
                1: blk_write($urandom_range(0, DEPTH + 2));
                2: do_read(8'h80 | 8'($urandom_range(0, DEPTH)), $urandom_range(1, 3), 1'b0);
                3: do_read(8'h00, $urandom_range(1, DEPTH + 2), 1'b0);
                default: bad_addr();
            endcase
        end

        // R11 idle after stop: a lone start and stop leave the line free
        b_start();
        b_stop();
        chk(sda_drive_low == 1'b0, "R11", {31'h0, sda_drive_low}, 32'h0);
        b_start();
        b_wbyte({DEV, 1'b0}, a);
        chk(a == 1'b1, "R11", {31'h0, a}, 32'h1);
        b_stop();

        // R10 pull-low changes only seen with the clock line low
        chk(viol == 0, "R10", viol, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule